// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Servicing

This peripheral watches over software through a small 32-bit register bus. It stays idle until software writes one specific 32-bit arming word. From then on a down-counter runs from a reload value, which is a 12-bit preload field scaled by a fixed power of two. Software keeps the system alive by writing an ordered pair of key words. That pair is accepted only while the counter sits inside a window at the end of the period, and the window size can be programmed.

A service pair that completes before the window opens counts as a violation. So does a counter that runs down to zero, and so does any malformed key write. Each violation sets a sticky status flag. It also fires a one-cycle pulse on either an interrupt output or a reset-request output, as chosen by a reaction register. Software can read back the configuration registers, the status flag and the live counter. Once armed, the watchdog cannot be stopped by software.

Top module: `win_watchdog`

## Requirements
- R1: After reset the block is disarmed, both pulse outputs are low, and reads of the control, status and counter registers return 0.
- R2: Writing 0xA98559DA to the control register (offset 0x90) arms the block. Any other value leaves it disarmed. A read of offset 0x90 returns the armed state in bit 0.
- R3: Once armed, no write disarms the block. Only the system reset clears the armed state.
- R4: The 12-bit preload at offset 0x94 gives a reload value of preload << PRELOAD_SHIFT. The counter takes the reload value when the block is armed and after each accepted service, and then drops by one per clock. Its value is readable at offset 0xA0.
- R5: When the armed counter is at 0 (a late service), a violation is raised and the counter takes the reload value again, so counting continues.
- R6: A service is 0x0000E51A written to the key register (offset 0x9C), which makes a service pending, followed by 0x0000A35C. If that second word arrives while a service is pending and the window is open, the counter reloads and no violation is raised. Writing 0xE51A again while a service is pending keeps it pending.
- R7: The window register at offset 0xA8 selects the fraction of the reload value: 0x5 gives 1/1, 0x50 gives 1/2, 0x500 gives 1/4, 0x5000 gives 1/8, 0x50000 gives 1/16 and 0x500000 gives 1/32. Any other value gives 1/1. The window is open when counter <= reload >> k, where 1/2^k is the selected fraction. A 0xA35C that completes a pending service while the window is closed is a violation and does not reload the counter.
- R8: A 0xA35C written with no service pending is a violation. So is any key word other than the two key values.
- R9: If the reaction register (offset 0xA4) holds 0xA, each violation gives a one-cycle pulse on irq_pulse. For any other value the pulse goes to rst_req. The pulse shows on the clock edge that registers the violating event.
- R10: Status bit 1 (offset 0x98) is set by any violation and stays set. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R11: While the block is disarmed, key writes cause no violation and no pulse.
- R12: Read data is registered and appears in the cycle after the read strobe. Unmapped offsets and the key register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pulse | output | 1 | One-cycle violation pulse in interrupt reaction mode |
| rst_req | output | 1 | One-cycle violation pulse in reset reaction mode |

## Verification
The hardest case to reach is a service pair that lands exactly one cycle on either side of the window edge. At that point the decision rests on a single count, and it can only be seen from the ports through a pulse and a later counter read. The stimulus arms the block from a fresh reset with a small preload scale. It then idles for an exact number of cycles, counted from the arming write, before the two key writes. Each edge is run twice, one cycle early and one cycle late, for three window fractions. A read of the counter right after each pair shows whether the reload took place.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register byte offsets; software decodes these.
  localparam logic [7:0] OFF_ARM    = 8'h90;
  localparam logic [7:0] OFF_RELOAD = 8'h94;
  localparam logic [7:0] OFF_FLAGS  = 8'h98;
  localparam logic [7:0] OFF_KEY    = 8'h9C;
  localparam logic [7:0] OFF_COUNT  = 8'hA0;
  localparam logic [7:0] OFF_ACTION = 8'hA4;
  localparam logic [7:0] OFF_WINDOW = 8'hA8;

  localparam logic [31:0] ARM_WORD  = 32'hA98559DA;
  localparam logic [31:0] KEY_OPEN  = 32'h0000E51A;
  localparam logic [31:0] KEY_CLOSE = 32'h0000A35C;
  localparam logic [31:0] ACT_IRQ   = 32'h0000000A;
  localparam logic [31:0] WIN_FULL  = 32'h00000005;

  typedef enum logic {SVC_IDLE, SVC_PEND} svc_e;
endpackage

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int CNT_W   = 25,
  parameter int DATA_W  = 32,
  parameter int NUM_WIN = 6
) (
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] code,
  output logic              win_open
);
  localparam int SH_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [NUM_WIN-1:0] hit;
  logic [SH_W-1:0]    sh;
  logic [CNT_W-1:0]   thr;

  // Encoding k is the nibble 5 placed k nibbles up: fraction 1/2^k.
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_code
    localparam logic [63:0] CODE = 64'h5 << (4 * k);
    assign hit[k] = (code == DATA_W'(CODE));
  end

  always_comb begin
    sh = '0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (hit[k]) sh = SH_W'(k);
    end
  end

  assign thr      = reload >> sh;
  assign win_open = (cnt <= thr);
endmodule

// File: rtl/wdt_svc_fsm.sv
module wdt_svc_fsm import wdt_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              win_open,
  output logic              svc_ok,
  output logic              svc_bad
);
  svc_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    svc_ok  = 1'b0;
    svc_bad = 1'b0;
    if (enable && key_wr) begin
      if (key_data == DATA_W'(KEY_OPEN)) begin
        state_d = SVC_PEND;
      end else if (key_data == DATA_W'(KEY_CLOSE) && state_q == SVC_PEND && win_open) begin
        svc_ok  = 1'b1;
        state_d = SVC_IDLE;
      end else begin
        svc_bad = 1'b1;
        state_d = SVC_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SVC_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog import wdt_pkg::*; #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int PRE_W         = 12,
  parameter int PRELOAD_SHIFT = 13,
  parameter int NUM_WIN       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              rst_req
);
  localparam int CNT_W = PRE_W + PRELOAD_SHIFT;

  logic              armed_q, flag_q;
  logic [PRE_W-1:0]  preload_q;
  logic [DATA_W-1:0] action_q, window_q;
  logic [CNT_W-1:0]  cnt, reload_val;
  logic              arm_now, expire, svc_ok, svc_bad, win_open, violation;
  logic              wr_arm, wr_reload, wr_flags, wr_key, wr_action, wr_window;

  assign wr_arm    = bus_wr && bus_addr == ADDR_W'(OFF_ARM);
  assign wr_reload = bus_wr && bus_addr == ADDR_W'(OFF_RELOAD);
  assign wr_flags  = bus_wr && bus_addr == ADDR_W'(OFF_FLAGS);
  assign wr_key    = bus_wr && bus_addr == ADDR_W'(OFF_KEY);
  assign wr_action = bus_wr && bus_addr == ADDR_W'(OFF_ACTION);
  assign wr_window = bus_wr && bus_addr == ADDR_W'(OFF_WINDOW);

  assign arm_now    = wr_arm && bus_wdata == DATA_W'(ARM_WORD) && !armed_q;
  assign reload_val = CNT_W'(preload_q) << PRELOAD_SHIFT;
  assign expire     = armed_q && cnt == '0;
  assign violation  = expire || svc_bad;

  wdt_downcount #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(armed_q),
    .load(arm_now || svc_ok || expire), .load_val(reload_val), .cnt(cnt)
  );

  wdt_window #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN)) u_window (
    .reload(reload_val), .cnt(cnt), .code(window_q), .win_open(win_open)
  );

  wdt_svc_fsm #(.DATA_W(DATA_W)) u_svc (
    .clk(clk), .rst(rst), .enable(armed_q), .key_wr(wr_key),
    .key_data(bus_wdata), .win_open(win_open), .svc_ok(svc_ok), .svc_bad(svc_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      flag_q    <= 1'b0;
      preload_q <= '1;
      action_q  <= '0;
      window_q  <= DATA_W'(WIN_FULL);
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (arm_now)   armed_q   <= 1'b1;
      if (wr_reload) preload_q <= bus_wdata[PRE_W-1:0];
      if (wr_action) action_q  <= bus_wdata;
      if (wr_window) window_q  <= bus_wdata;
      if (violation)                   flag_q <= 1'b1;
      else if (wr_flags && bus_wdata[1]) flag_q <= 1'b0;
      irq_pulse <= violation && action_q == DATA_W'(ACT_IRQ);
      rst_req   <= violation && action_q != DATA_W'(ACT_IRQ);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFF_ARM):    bus_rdata <= DATA_W'(armed_q);
        ADDR_W'(OFF_RELOAD): bus_rdata <= DATA_W'(preload_q);
        ADDR_W'(OFF_FLAGS):  bus_rdata <= DATA_W'({flag_q, 1'b0});
        ADDR_W'(OFF_COUNT):  bus_rdata <= DATA_W'(cnt);
        ADDR_W'(OFF_ACTION): bus_rdata <= action_q;
        ADDR_W'(OFF_WINDOW): bus_rdata <= window_q;
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             svc_ok,
  input logic             flag,
  input logic             irq_pulse,
  input logic             rst_req
);
  p_armed_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !svc_ok && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  p_expire_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt == '0) |=> flag);

  p_one_output_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_pulse, rst_req}));

  p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse || rst_req) |-> flag);

  p_quiet_disarmed_r11: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (!irq_pulse && !rst_req));
endmodule

bind win_watchdog wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
  .clk(clk), .rst(rst), .armed(armed_q), .cnt(cnt), .svc_ok(svc_ok),
  .flag(flag_q), .irq_pulse(irq_pulse), .rst_req(rst_req)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int SHIFT = 4;
  localparam logic [31:0] PRE = 32'd4;
  localparam logic [31:0] RLD = PRE << SHIFT; // 64

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse, rst_req;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_hit = 1'b0;

  always #2.5 clk = ~clk;

  win_watchdog #(.PRELOAD_SHIFT(SHIFT)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse), .rst_req(rst_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per completed read.
  always @(posedge clk) rd_hit <= bus_rd;
  always @(negedge clk) begin
    if (rd_hit && exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic arm(input logic [31:0] win, input logic [31:0] act);
    wr(8'h94, PRE);
    wr(8'hA8, win);
    wr(8'hA4, act);
    wr(8'h90, 32'hA98559DA);
  endtask

  // Service pair after n idle cycles from arming; checks the irq pulse.
  task automatic svc_after(input logic [31:0] win, input int n, input logic early, input string tag);
    reset_dut();
    arm(win, 32'hA);
    idle(n);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    chk({31'b0, irq_pulse}, {31'b0, early}, tag);
    rd(8'hA0, early ? RLD - 32'(n) - 32'd2 : RLD, {tag, " count"});
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    reset_dut();
    // R1 reset state
    chk({30'b0, irq_pulse, rst_req}, 32'd0, "R1 pulses");
    rd(8'h90, 0, "R1 ctrl");
    rd(8'h98, 0, "R1 status");
    rd(8'hA0, 0, "R1 count");

    // R2 wrong arming word, R11 keys ignored while disarmed
    wr(8'h90, 32'h12345678);
    rd(8'h90, 0, "R2 wrong word");
    wr(8'h9C, 32'hA35C);
    chk({30'b0, irq_pulse, rst_req}, 32'd0, "R11 key disarmed");
    wr(8'h9C, 32'h1111);
    chk({30'b0, irq_pulse, rst_req}, 32'd0, "R11 bad key disarmed");
    rd(8'h98, 0, "R11 status");
    rd(8'hA0, 0, "R11 count idle");

    // R2/R3/R4/R5/R9/R10 in reset reaction mode
    reset_dut();
    arm(32'h5, 32'h0);
    rd(8'hA0, RLD, "R4 count loaded");
    rd(8'h90, 1, "R2 armed");
    wr(8'h90, 32'h0);
    rd(8'h90, 1, "R3 still armed");
    rd(8'h94, PRE, "R4 preload readback");
    idle(59);
    chk({30'b0, irq_pulse, rst_req}, 32'd0, "R5 not yet expired");
    idle(1);
    chk({30'b0, irq_pulse, rst_req}, 32'd1, "R9 reset pulse on expiry");
    idle(1);
    chk({31'b0, rst_req}, 32'd0, "R9 single cycle");
    rd(8'hA0, RLD - 1, "R5 counter reloaded");
    rd(8'h98, 2, "R10 flag set");
    wr(8'h98, 32'h0);
    rd(8'h98, 2, "R10 write0 keeps");
    wr(8'h98, 32'h2);
    rd(8'h98, 0, "R10 write1 clears");

    // R6/R7 window edges
    svc_after(32'h50, 30, 1'b1, "R7 early 1/2");
    svc_after(32'h50, 31, 1'b0, "R6 ok 1/2");
    svc_after(32'h500, 46, 1'b1, "R7 early 1/4");
    svc_after(32'h500, 47, 1'b0, "R7 ok 1/4");
    svc_after(32'h500000, 60, 1'b1, "R7 early 1/32");
    svc_after(32'h500000, 61, 1'b0, "R7 ok 1/32");
    svc_after(32'h55, 0, 1'b0, "R7 unknown code full");
    svc_after(32'h5, 0, 1'b0, "R7 full window");

    // R8 key order, R6 repeated open key, R9 irq mode
    reset_dut();
    arm(32'h5, 32'hA);
    rd(8'hA4, 32'hA, "R9 action readback");
    rd(8'hA8, 32'h5, "R7 window readback");
    wr(8'h9C, 32'hA35C);
    chk({30'b0, irq_pulse, rst_req}, 32'd2, "R8 close without open");
    idle(1);
    chk({31'b0, irq_pulse}, 32'd0, "R9 irq single cycle");
    wr(8'h9C, 32'h1234);
    chk({31'b0, irq_pulse}, 32'd1, "R8 other key");
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hE51A);
    chk({31'b0, irq_pulse}, 32'd0, "R6 repeated open");
    wr(8'h9C, 32'hA35C);
    chk({31'b0, irq_pulse}, 32'd0, "R6 service after repeat");
    rd(8'hA0, RLD, "R6 reload after repeat");

    // R5 late in irq mode, counting continues
    reset_dut();
    arm(32'h5, 32'hA);
    idle(64);
    chk({31'b0, irq_pulse}, 32'd0, "R5 irq not yet");
    idle(1);
    chk({30'b0, irq_pulse, rst_req}, 32'd2, "R5 irq on expiry");
    rd(8'hA0, RLD, "R5 keeps running");

    // R12 unmapped and key reads
    rd(8'h40, 0, "R12 unmapped");
    rd(8'h9C, 0, "R12 key reads zero");
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule